// File: doc/BRIEF.md
# Divide-by-Three Processor Clock Generator

This block turns a fast reference into the clocks that a processor and its peripherals use. A static strap chooses the reference: either the crystal oscillator input or an externally supplied frequency. The selected reference drives a three-state counter. The counter produces a processor clock at one third of the reference rate, high for one reference period out of every three. A second divider toggles on each processor-clock rise and gives a peripheral clock at half the processor rate with an even duty cycle. The crystal input is also passed straight through as an oscillator output, so other logic can tap the raw frequency.

A synchronous clear input stops the dividers. While clear is high, the counter stays in its first state and both divided clocks stay low. When clear drops, the sequence restarts from a known phase. Several generators that share a clear can therefore be brought into step. A reset request is sampled only when the processor clock falls, which gives the processor a reset aligned to its own clock. Two one-cycle strobes warn logic in the reference domain that the processor clock will rise or fall at the next reference edge.

All state lives in the selected reference domain. The divided clocks, the strobes and the reset output all come straight from registers.

Top module: `cpu_clk_gen`

## Requirements
- R1: With `src_ext_i` high the processor clock period is three periods of `ext_clk_i`; with it low the period is three periods of `xtal_clk_i`.
- R2: Outside clear, the processor clock is high for exactly one reference period out of every three, repeating with period three.
- R3: The peripheral clock toggles at every processor-clock rise, so its period is six reference periods and it is high for three of them.
- R4: While `clr_i` is sampled high, the counter is held in its first state and the processor clock, peripheral clock and both strobes are low.
- R5: Let the first edge at which `clr_i` is sampled low be edge 1. The processor clock is low after edges 1 and 2 and first rises at edge 3. Every rise after that follows at steps of three edges.
- R6: `osc_o` is the `xtal_clk_i` input, passed through unchanged whatever the strap selects.
- R7: `cpu_rst_o` takes the value of `rst_req_i` at each reference edge where the processor clock goes from high to low, and holds its value at every other edge.
- R8: `rise_stb_o` is high for the one reference period just before a processor-clock rise. `fall_stb_o` is high for the one reference period just before a processor-clock fall.
- R9: While `rst_ni` is low, the processor clock, peripheral clock and both strobes are low and `cpu_rst_o` is high. Internal release takes two reference edges after `rst_ni` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xtal_clk_i | input | 1 | Crystal oscillator reference |
| ext_clk_i | input | 1 | External frequency reference |
| src_ext_i | input | 1 | Strap: 1 selects the external reference, 0 the crystal |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Synchronous clear that holds the dividers (active high) |
| rst_req_i | input | 1 | Reset request, sampled when the processor clock falls |
| cpu_clk_o | output | 1 | Processor clock, reference/3, one-third high |
| per_clk_o | output | 1 | Peripheral clock, processor/2, even duty |
| osc_o | output | 1 | Crystal reference passed through |
| cpu_rst_o | output | 1 | Processor reset, aligned to the processor-clock fall |
| rise_stb_o | output | 1 | One reference cycle ahead of a processor-clock rise |
| fall_stb_o | output | 1 | One reference cycle ahead of a processor-clock fall |

## Verification
The properties assume that `clr_i` and `rst_req_i` are already synchronous to the selected reference. They also assume that the strap changes only while `rst_ni` is low, because the source multiplexer has no glitch protection. The stimulus respects both assumptions. It changes clear and the request on the falling edge of the crystal clock and switches the strap only during reset. One clear pulse is placed so that it lands while the processor clock is high. That case checks the forced fall and the reset capture it causes.

// File: rtl/cpu_clk_gen_pkg.sv
`timescale 1ns/1ps
package cpu_clk_gen_pkg;

  // Counter width needed to hold states 0 .. n-1 (at least one bit).
  function automatic int cnt_width(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

  // Number of stages in the reset release synchronizer.
  localparam int RST_STAGES_DEF = 2;

endpackage

// File: rtl/cpu_clk_gen_src.sv
`timescale 1ns/1ps
module cpu_clk_gen_src (
  input  logic xtal_i,
  input  logic ext_i,
  input  logic sel_ext_i,
  output logic ref_o,
  output logic osc_o
);
  // Static strap: the selection is not glitch-protected.
  always_comb begin
    if (sel_ext_i) ref_o = ext_i;
    else           ref_o = xtal_i;
  end

  // The raw crystal input is passed through (R6).
  assign osc_o = xtal_i;

endmodule

// File: rtl/cpu_clk_gen_rsync.sv
`timescale 1ns/1ps
module cpu_clk_gen_rsync #(
  parameter int STAGES = cpu_clk_gen_pkg::RST_STAGES_DEF
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q, sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/cpu_clk_gen_div.sv
`timescale 1ns/1ps
module cpu_clk_gen_div #(
  parameter int DIV_N  = 3,
  parameter int HIGH_N = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic cclk_o,
  output logic rise_stb_o,
  output logic fall_stb_o,
  output logic rise_now_o,
  output logic fall_now_o
);
  localparam int CW = cpu_clk_gen_pkg::cnt_width(DIV_N);
  localparam logic [CW-1:0] LAST  = CW'(DIV_N - 1);
  localparam logic [CW-1:0] HLAST = CW'(HIGH_N - 1);
  localparam logic [CW-1:0] HCNT  = CW'(HIGH_N);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cclk_q, cclk_d;
  logic          rs_q, rs_d;
  logic          fs_q, fs_d;
  logic          run_en;

  // Next-state logic
  always_comb begin
    run_en = !clr_i;
    if (!run_en)            cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + CW'(1);
    cclk_d     = run_en && (cnt_d < HCNT);
    rs_d       = run_en && (cnt_d == LAST);
    fs_d       = run_en && (cnt_d == HLAST);
    rise_now_o = cclk_d && !cclk_q;
    fall_now_o = cclk_q && !cclk_d;
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cclk_q <= 1'b0;
      rs_q   <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cclk_q <= cclk_d;
      rs_q   <= rs_d;
      fs_q   <= fs_d;
    end
  end

  assign cclk_o     = cclk_q;
  assign rise_stb_o = rs_q;
  assign fall_stb_o = fs_q;

  // R2: the counter never leaves its legal range
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R4: a sampled clear leaves the divider in its first state with the clock low
  p_clear_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!cclk_q && cnt_q == '0));
  // R8: the rise strobe is followed by a clock rise
  p_rise_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_q && !clr_i) |=> $rose(cclk_q));
  // R8: the fall strobe is followed by a clock fall
  p_fall_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_q && !clr_i) |=> $fell(cclk_q));

endmodule

// File: rtl/cpu_clk_gen_pdiv.sv
`timescale 1ns/1ps
module cpu_clk_gen_pdiv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic rise_now_i,
  output logic pclk_o
);
  logic pclk_q, pclk_d, tgl_en;

  always_comb begin
    tgl_en = rise_now_i && !clr_i;
    if (clr_i)       pclk_d = 1'b0;
    else if (tgl_en) pclk_d = !pclk_q;
    else             pclk_d = pclk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pclk_q <= 1'b0;
    else         pclk_q <= pclk_d;
  end

  assign pclk_o = pclk_q;

  // R3: the peripheral clock changes at each processor-clock rise
  p_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_now_i && !clr_i) |=> (pclk_q != $past(pclk_q)));
  // R3: the peripheral clock holds between rises
  p_steady_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_now_i && !clr_i) |=> $stable(pclk_q));
  // R4: a sampled clear leaves the peripheral clock low
  p_clear_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pclk_q);

endmodule

// File: rtl/cpu_clk_gen_rstreg.sv
`timescale 1ns/1ps
module cpu_clk_gen_rstreg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_now_i,
  input  logic req_i,
  output logic cpu_rst_o
);
  logic rst_q, rst_d;

  always_comb begin
    if (fall_now_i) rst_d = req_i;
    else            rst_d = rst_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b1;
    else         rst_q <= rst_d;
  end

  assign cpu_rst_o = rst_q;

  // R7: the request is taken at a processor-clock fall
  p_take_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_now_i |=> (rst_q == $past(req_i)));
  // R7: the output holds at every other edge
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_now_i |=> $stable(rst_q));

endmodule

// File: rtl/cpu_clk_gen.sv
`timescale 1ns/1ps
module cpu_clk_gen #(
  parameter int DIV_N      = 3,
  parameter int HIGH_N     = 1,
  parameter int RST_STAGES = cpu_clk_gen_pkg::RST_STAGES_DEF
) (
  input  logic xtal_clk_i,
  input  logic ext_clk_i,
  input  logic src_ext_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic rst_req_i,
  output logic cpu_clk_o,
  output logic per_clk_o,
  output logic osc_o,
  output logic cpu_rst_o,
  output logic rise_stb_o,
  output logic fall_stb_o
);
  logic ref_clk;
  logic int_rst_n;
  logic rise_now, fall_now;

  cpu_clk_gen_src u_src (
    .xtal_i    (xtal_clk_i),
    .ext_i     (ext_clk_i),
    .sel_ext_i (src_ext_i),
    .ref_o     (ref_clk),
    .osc_o     (osc_o)
  );

  cpu_clk_gen_rsync #(.STAGES(RST_STAGES)) u_rsync (
    .clk_i   (ref_clk),
    .arst_ni (rst_ni),
    .rst_no  (int_rst_n)
  );

  cpu_clk_gen_div #(.DIV_N(DIV_N), .HIGH_N(HIGH_N)) u_div (
    .clk_i      (ref_clk),
    .rst_ni     (int_rst_n),
    .clr_i      (clr_i),
    .cclk_o     (cpu_clk_o),
    .rise_stb_o (rise_stb_o),
    .fall_stb_o (fall_stb_o),
    .rise_now_o (rise_now),
    .fall_now_o (fall_now)
  );

  cpu_clk_gen_pdiv u_pdiv (
    .clk_i      (ref_clk),
    .rst_ni     (int_rst_n),
    .clr_i      (clr_i),
    .rise_now_i (rise_now),
    .pclk_o     (per_clk_o)
  );

  cpu_clk_gen_rstreg u_rstreg (
    .clk_i      (ref_clk),
    .rst_ni     (int_rst_n),
    .fall_now_i (fall_now),
    .req_i      (rst_req_i),
    .cpu_rst_o  (cpu_rst_o)
  );

endmodule

// File: tb/cpu_clk_gen_tb_top.sv
`timescale 1ns/1ps
module cpu_clk_gen_tb_top;
  logic xtal_clk = 1'b0;
  logic ext_clk  = 1'b0;
  logic src_ext, rst_n, clr, req;
  logic cpu_clk, per_clk, osc, cpu_rst, rise_stb, fall_stb;

  always #2 xtal_clk = ~xtal_clk; // 250 MHz
  always #3 ext_clk  = ~ext_clk;  // 6 ns external reference

  cpu_clk_gen dut_i (
    .xtal_clk_i (xtal_clk),
    .ext_clk_i  (ext_clk),
    .src_ext_i  (src_ext),
    .rst_ni     (rst_n),
    .clr_i      (clr),
    .rst_req_i  (req),
    .cpu_clk_o  (cpu_clk),
    .per_clk_o  (per_clk),
    .osc_o      (osc),
    .cpu_rst_o  (cpu_rst),
    .rise_stb_o (rise_stb),
    .fall_stb_o (fall_stb)
  );

  typedef struct {
    logic clk;
    logic pclk;
    logic rise;
    logic fall;
    logic rst;
    int   ctag;
    int   ptag;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  int   k = 0;
  logic prev_clk = 1'b0;
  logic rst_exp  = 1'b1;

  task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_num(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: applies one reference cycle of stimulus and queues the expected outputs.
  // The model counts edges since clear release (R5) and uses a period of three (R2)
  // and a toggle at each rise (R3). The reset is captured on a high-to-low step (R7).
  // The strobes lead the clock edges (R8). Everything is zero while clear is high (R4).
  task automatic drive_cycle(input logic c, input logic r);
    exp_t e;
    @(negedge xtal_clk);
    clr = c;
    req = r;
    if (c) k = 0;
    else   k++;
    e.clk  = !c && (k > 0) && (k % 3 == 0);
    e.rise = !c && (k % 3 == 2);
    e.fall = e.clk;
    e.pclk = !c && ((k / 3) % 2 == 1);
    if (prev_clk && !e.clk) rst_exp = r;
    e.rst  = rst_exp;
    prev_clk = e.clk;
    e.ctag = c ? 4 : ((k <= 3) ? 5 : 2);
    e.ptag = c ? 4 : 3;
    sb_q.push_back(e);
  endtask

  // Monitor: samples 1 ns after each reference rise and compares with the queue.
  initial begin
    forever begin
      @(posedge xtal_clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check_bit($sformatf("R%0d", e.ctag), "cpu_clk", cpu_clk, e.clk);
        check_bit($sformatf("R%0d", e.ptag), "per_clk", per_clk, e.pclk);
        check_bit("R8", "rise_stb", rise_stb, e.rise);
        check_bit("R8", "fall_stb", fall_stb, e.fall);
        check_bit("R7", "cpu_rst", cpu_rst, e.rst);
      end
    end
  end

  // Watchdog
  initial begin
    #800000;
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  realtime t0, t1, t2;

  initial begin
    src_ext = 1'b0;
    rst_n   = 1'b0;
    clr     = 1'b1;
    req     = 1'b0;
    repeat (3) @(negedge xtal_clk);
    // R9: state while reset is held
    check_bit("R9", "cpu_clk in reset", cpu_clk, 1'b0);
    check_bit("R9", "per_clk in reset", per_clk, 1'b0);
    check_bit("R9", "rise_stb in reset", rise_stb, 1'b0);
    check_bit("R9", "fall_stb in reset", fall_stb, 1'b0);
    check_bit("R9", "cpu_rst in reset", cpu_rst, 1'b1);
    rst_n = 1'b1;
    repeat (5) @(negedge xtal_clk);
    // R4: clear still held after the internal release
    check_bit("R4", "cpu_clk in clear", cpu_clk, 1'b0);
    check_bit("R4", "per_clk in clear", per_clk, 1'b0);

    // R2, R3, R5, R7, R8: long run with a varying request pattern
    drive_cycle(1'b1, 1'b0);
    for (int i = 0; i < 60; i++) drive_cycle(1'b0, (i % 11) < 5);
    // R4: clear pulse in the middle of the sequence, then realignment
    drive_cycle(1'b1, 1'b1);
    drive_cycle(1'b1, 1'b1);
    for (int i = 0; i < 30; i++) drive_cycle(1'b0, (i % 4) == 0);
    // Clear while the processor clock is high: forced fall captures the request (R7)
    drive_cycle(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) drive_cycle(1'b0, 1'b1);
    drive_cycle(1'b1, 1'b0);
    for (int i = 0; i < 40; i++) drive_cycle(1'b0, (i % 7) < 2);
    while (sb_q.size() > 0) @(posedge xtal_clk);
    repeat (2) @(posedge xtal_clk);

    // R1/R2: period with the crystal reference
    @(posedge cpu_clk); t0 = $realtime;
    @(posedge cpu_clk); t1 = $realtime;
    check_num("R1", "xtal cpu_clk period ns", int'(t1 - t0), 12);
    // R3: peripheral period and high time
    @(posedge per_clk); t0 = $realtime;
    @(negedge per_clk); t1 = $realtime;
    @(posedge per_clk); t2 = $realtime;
    check_num("R3", "per_clk high ns", int'(t1 - t0), 12);
    check_num("R3", "per_clk period ns", int'(t2 - t0), 24);

    // R1: switch the strap only under reset
    @(negedge xtal_clk);
    rst_n = 1'b0;
    #1;
    src_ext = 1'b1;
    #20;
    rst_n = 1'b1;
    @(posedge cpu_clk); t0 = $realtime;
    @(posedge cpu_clk); t1 = $realtime;
    check_num("R1", "ext cpu_clk period ns", int'(t1 - t0), 18);
    @(negedge cpu_clk); t2 = $realtime;
    check_num("R2", "ext cpu_clk high ns", int'(t2 - t1), 6);
    // R6: oscillator output follows the crystal even with the external source selected
    for (int i = 0; i < 8; i++) begin
      #1.3;
      check_bit("R6", "osc vs xtal", osc, xtal_clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule